// File: doc/BRIEF.md
# Seven-Bit PWM Generator with Alternate-Period Extension

This block produces a pulse-width modulated level from a 7-bit up counter that spans 128 source-clock ticks per period. A source-clock enable advances the counter, and a run input starts and stops it. Within each period the output starts at a programmable start level, switches to the opposite (active) level once the counter reaches the duty value, and returns to the start level when the counter wraps. Each wrap also raises a one-clock interrupt pulse.

An optional extension mode moves the switch point one tick later on every second period of a run. Alternating a period at `duty` with one at `duty+1` gives an average resolution close to eight bits over a pair of periods. A combine control can gate the result with a second PWM stream so that the pin carries the AND of both, which suits carrier-modulated waveforms such as remote-control pulses.

Duty and extension settings are held in shadow registers that are reloaded while the block is stopped and at every wrap, so a change made while running never splits a period.

Top module: `alt_pwm7`

## Requirements
- R1: While `run_i` is high, the counter advances once per clock with `tick_i` high and holds otherwise; one period is 128 ticks, and `wrap_irq_o` is high for exactly one clock after the tick on which the count was 127.
- R2: The output is registered; after the tick on which the count equals the active switch point it takes the active level (the inverse of `start_lvl_i`), and after the wrap tick (count 127) it returns to the start level.
- R3: With `start_lvl_i` = 0 the start level is low and the active level high; with `start_lvl_i` = 1 both are inverted.
- R4: While `run_i` is low the counter is held at 0 and, one clock after `run_i` falls, `pwm_o` equals `start_lvl_i` (when `and_en_i` = 0).
- R5: With extension enabled, the periods of a run are numbered from 0 and every odd-numbered period switches at count `duty+1` instead of `duty`.
- R6: With extension disabled, every period switches at count `duty`.
- R7: Period numbering restarts at 0 on each rise of `run_i`, so the first period after a restart is never extended.
- R8: `duty_i` and `ext_en_i` are captured while stopped and at each wrap; a change during a period takes effect from the next period.
- R9: When the switch point is 127 or 128, the wrap takes priority and the output stays at the start level for the whole period.
- R10: With `and_en_i` = 1, `pwm_o` is the AND of the internal level and `alt_i`; with `and_en_i` = 0, `alt_i` has no effect.
- R11: After reset `pwm_o` and `wrap_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Source-clock enable; one counter step per high cycle |
| run_i | input | 1 | Run enable; low stops and clears the counter |
| duty_i | input | 7 | Switch point within the 128-tick period |
| ext_en_i | input | 1 | Extension mode: odd-numbered periods switch one tick later |
| start_lvl_i | input | 1 | Start and idle level of the output |
| and_en_i | input | 1 | Gate the output with `alt_i` |
| alt_i | input | 1 | Second PWM stream for the AND combine |
| pwm_o | output | 1 | Registered PWM level |
| wrap_irq_o | output | 1 | One-clock pulse per counter wrap |

## Verification
Two events can land on the same tick: the delayed switch of an extended period and the counter wrap. Running with duty 127 and extension enabled places the extended switch point at 128, and duty 127 without extension places it on the wrap tick itself. The bench checks every sample of those periods, expecting the start level throughout and a single interrupt pulse at count 127, so a design that lets the switch win over the wrap is caught.

// File: rtl/alt_pwm7_pkg.sv
package alt_pwm7_pkg;

  // Phase of the current period: before or after the switch point.
  typedef enum logic {
    PH_START  = 1'b0,
    PH_ACTIVE = 1'b1
  } phase_e;

endpackage

// File: rtl/alt_pwm7_count.sv
module alt_pwm7_count #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             odd_per
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap = run && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      odd_per <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      odd_per <= 1'b0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (wrap) odd_per <= ~odd_per;
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));

  // R4
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  // R7
  parity_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !odd_per);

endmodule

// File: rtl/alt_pwm7_wave.sv
module alt_pwm7_wave
  import alt_pwm7_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             odd_per,
  input  logic [CNT_W-1:0] duty,
  input  logic             ext_en,
  input  logic             start_lvl,
  input  logic             and_en,
  input  logic             alt,
  output logic             pwm_o
);

  localparam int PT_W = CNT_W + 1;

  logic [CNT_W-1:0] duty_act;
  logic             ext_act;
  logic [PT_W-1:0]  sw_pt;
  logic             hit;
  phase_e           ph_q, ph_d;
  logic             lvl_d;

  // Shadow settings: follow inputs while stopped, reload at each wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      ext_act  <= 1'b0;
    end else if (!run || wrap) begin
      duty_act <= duty;
      ext_act  <= ext_en;
    end
  end

  assign sw_pt = {1'b0, duty_act} + {{CNT_W{1'b0}}, (ext_act & odd_per)};
  assign hit   = run && tick && !wrap && ({1'b0, cnt} == sw_pt);

  always_comb begin
    ph_d = ph_q;
    if (!run || wrap) ph_d = PH_START;
    else if (hit)     ph_d = PH_ACTIVE;
  end

  assign lvl_d = (ph_d == PH_ACTIVE) ^ start_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_START;
      pwm_o <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      pwm_o <= and_en ? (lvl_d & alt) : lvl_d;
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(duty_act) && $stable(ext_act)));

  // R9
  wrap_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ph_q == PH_START));

  // R4
  stop_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !and_en) |=> (pwm_o == $past(start_lvl)));

  // R10
  and_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (and_en && !alt) |=> !pwm_o);

endmodule

// File: rtl/alt_pwm7.sv
module alt_pwm7 #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             ext_en_i,
  input  logic             start_lvl_i,
  input  logic             and_en_i,
  input  logic             alt_i,
  output logic             pwm_o,
  output logic             wrap_irq_o
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             odd_per;

  alt_pwm7_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .run     (run_i),
    .tick    (tick_i),
    .cnt     (cnt),
    .wrap    (wrap),
    .odd_per (odd_per)
  );

  alt_pwm7_wave #(.CNT_W(CNT_W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .run       (run_i),
    .tick      (tick_i),
    .cnt       (cnt),
    .wrap      (wrap),
    .odd_per   (odd_per),
    .duty      (duty_i),
    .ext_en    (ext_en_i),
    .start_lvl (start_lvl_i),
    .and_en    (and_en_i),
    .alt       (alt_i),
    .pwm_o     (pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wrap_irq_o <= 1'b0;
    else     wrap_irq_o <= wrap;
  end

  // R1
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_irq_o |=> !wrap_irq_o);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pwm_o && !wrap_irq_o));

endmodule

// File: tb/alt_pwm7_test.sv
module alt_pwm7_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       gate = 1'b0;
  logic       run = 1'b0;
  logic [6:0] duty = '0;
  logic       ext_en = 1'b0;
  logic       start_lvl = 1'b0;
  logic       and_en = 1'b0;
  logic       alt = 1'b0;
  logic       pwm;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always @(negedge clk) tick <= gate ? ~tick : 1'b1;

  alt_pwm7 uut (
    .clk(clk), .rst(rst), .tick_i(tick), .run_i(run), .duty_i(duty),
    .ext_en_i(ext_en), .start_lvl_i(start_lvl), .and_en_i(and_en),
    .alt_i(alt), .pwm_o(pwm), .wrap_irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected level at count c of a period with switch point m.
  function automatic logic exp_lvl(input int c, input int m, input logic sl);
    return ((c >= m) && (c != 127)) ? ~sl : sl;
  endfunction

  // Check one full period sample by sample; mext is the switch point.
  task automatic check_period(input int m, input logic sl, input logic gate_on,
                              input string tag);
    int bad = 0;
    int badirq = 0;
    int fa = 0;
    int fe = 0;
    for (int c = 0; c < 128; c++) begin
      logic e;
      step();
      e = exp_lvl(c, m, sl);
      if (gate_on) e = e & alt;
      if (pwm !== e) begin
        if (bad == 0) begin fa = pwm; fe = e; end
        bad++;
      end
      if (irq !== (c == 127)) badirq++;
    end
    chk(bad == 0, tag, fa, fe);
    chk(badirq == 0, "R1 wrap pulse at count 127", badirq, 0);
  endtask

  task automatic stop_check(input logic sl, input string tag);
    run = 1'b0;
    step();
    chk(pwm === sl, tag, pwm, sl);
  endtask

  task automatic run_periods(input int d, input logic ext, input logic sl,
                             input int nper, input string tag);
    duty = d[6:0]; ext_en = ext; start_lvl = sl;
    step();
    run = 1'b1;
    for (int p = 0; p < nper; p++) begin
      int m = d + ((ext && (p % 2 == 1)) ? 1 : 0);
      check_period(m, sl, and_en, tag);
    end
    stop_check(sl, "R4 stop returns to start level");
  endtask

  task automatic t_reset();
    chk(pwm === 1'b0 && irq === 1'b0, "R11 reset state", {pwm, irq}, 0);
  endtask

  task automatic t_idle();
    start_lvl = 1'b1; step();
    chk(pwm === 1'b1, "R4 idle shows start level 1", pwm, 1);
    start_lvl = 1'b0; step();
    chk(pwm === 1'b0, "R4 idle shows start level 0", pwm, 0);
  endtask

  task automatic t_basic();
    run_periods(40, 1'b0, 1'b0, 2, "R2 R6 duty 40 no extension");
    run_periods(100, 1'b0, 1'b1, 2, "R3 inverted polarity duty 100");
  endtask

  task automatic t_ext();
    run_periods(40, 1'b1, 1'b0, 4, "R5 extension duty 40");
    run_periods(17, 1'b1, 1'b1, 2, "R3 R5 extension inverted");
    run_periods(0, 1'b1, 1'b0, 2, "R5 extension duty 0");
  endtask

  task automatic t_wrap_priority();
    run_periods(127, 1'b1, 1'b0, 2, "R9 duty 127 with extension");
    run_periods(127, 1'b0, 1'b1, 1, "R9 duty 127 no extension");
    run_periods(126, 1'b1, 1'b0, 2, "R9 duty 126 extended to 127");
  endtask

  task automatic t_shadow();
    duty = 7'd20; ext_en = 1'b0; start_lvl = 1'b0;
    step();
    run = 1'b1;
    for (int c = 0; c < 60; c++) step();
    duty = 7'd90; ext_en = 1'b1;
    begin
      int bad = 0;
      for (int c = 60; c < 128; c++) begin
        step();
        if (pwm !== exp_lvl(c, 20, 1'b0)) bad++;
      end
      chk(bad == 0, "R8 mid-period change deferred", bad, 0);
    end
    check_period(91, 1'b0, 1'b0, "R8 new duty and extension from next period");
    stop_check(1'b0, "R4 stop after shadow test");
  endtask

  task automatic t_restart();
    duty = 7'd30; ext_en = 1'b1; start_lvl = 1'b0;
    step();
    run = 1'b1;
    for (int c = 0; c < 128 + 50; c++) step();
    stop_check(1'b0, "R4 stop in extended period");
    run_periods(30, 1'b1, 1'b0, 2, "R7 parity restarts on run");
  endtask

  task automatic t_and();
    and_en = 1'b1; alt = 1'b0;
    run_periods(50, 1'b0, 1'b0, 1, "R10 AND with low stream");
    alt = 1'b1;
    run_periods(50, 1'b1, 1'b0, 2, "R10 AND with high stream");
    and_en = 1'b0; alt = 1'b0;
    run_periods(50, 1'b0, 1'b0, 1, "R10 stream ignored when combine off");
  endtask

  task automatic t_gate();
    int first = -1;
    int second = -1;
    duty = 7'd10; ext_en = 1'b0; start_lvl = 1'b0;
    gate = 1'b1;
    step(); step();
    run = 1'b1;
    for (int i = 0; i < 700 && second < 0; i++) begin
      step();
      if (irq === 1'b1) begin
        if (first < 0) first = i;
        else second = i;
      end
    end
    chk((second - first) == 256, "R1 period counts ticks only", second - first, 256);
    run = 1'b0; gate = 1'b0;
    step(); step();
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    t_reset();
    t_idle();
    t_basic();
    t_ext();
    t_wrap_priority();
    t_shadow();
    t_restart();
    t_and();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule